// File: doc/BRIEF.md
# Dual-Clock Byte FIFO with Early-Warning Flags

This block carries byte-wide words from one clock domain to another whose clock bears no relation to the first. The producer pushes a word by holding `wr_en` high for one `wr_clk` cycle. Two flags in the producer's own domain guard those pushes. `wr_full` says no more words fit. `wr_almost_full` rises one word earlier. `wr_count` reports the stored words as the write side sees them. The consumer side mirrors this on `rd_clk` with `rd_empty`, `rd_almost_empty` and `rd_count`. A read returns its word on `rd_data` one read-clock cycle after the read is sampled.

The storage is a 256-entry dual-port array. One slot is always kept free, so at most 255 words are held and an 8-bit count can show them all. Each side keeps a 9-bit binary pointer and publishes it as Gray code. A two-flop synchronizer carries it into the other domain, where it is converted back to binary. Each side computes its flags from its own pointer and from the other side's delayed pointer. The flags can therefore be late in reporting room or data, but never early.

A single active-low reset clears both sides at once. Each domain releases it synchronously on its own clock.

Top module: `xclk_fifo`

## Requirements
- R1: While reset is held, and after it is released with no traffic, `wr_full`=0, `wr_almost_full`=0, `wr_count`=0, `rd_empty`=1, `rd_almost_empty`=1, `rd_count`=0 and `rd_data`=0.
- R2: Words leave in the order they entered. A read is accepted when `rd_en`=1 and `rd_empty`=0 at a `rd_clk` rising edge, and that edge places the word on `rd_data`.
- R3: From empty, exactly 255 writes are accepted. `wr_full` rises at the `wr_clk` edge that stores the 255th word, and `wr_count` then reads 255.
- R4: A write presented while `wr_full`=1 is dropped. The count stays at 255, and the dropped word is never read out.
- R5: A read presented while `rd_empty`=1 is dropped. `rd_count` stays 0, and `rd_data` keeps its value on every edge that accepts no read.
- R6: `wr_almost_full`=1 exactly when `wr_count` ≥ 254. It is therefore high on the write after which one slot remains, and whenever `wr_full` is high. `wr_full`=1 exactly when `wr_count`=255.
- R7: `rd_almost_empty`=1 exactly when `rd_count` ≤ 1. `rd_empty`=1 exactly when `rd_count`=0.
- R8: Each count equals its own side's transfers minus the other side's transfers as seen through the synchronizer. After a few quiet cycles, both counts equal the true number of stored words.
- R9: Flags are pessimistic. `wr_count` is never below the true occupancy, and `rd_count` never above it. A transfer in one domain reaches the other domain's count on the third rising edge of that domain's clock: not on the first, and within five cycles when observed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Push request |
| wr_data | input | 8 | Word to push |
| wr_full | output | 1 | No free slot; pushes are dropped |
| wr_almost_full | output | 1 | At most one free slot |
| wr_count | output | 8 | Stored words as seen by the write side |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Pop request |
| rd_data | output | 8 | Word returned by the last accepted pop |
| rd_empty | output | 1 | Nothing stored; pops are dropped |
| rd_almost_empty | output | 1 | At most one stored word |
| rd_count | output | 8 | Stored words as seen by the read side |

## Verification
The bench uses the default parameters: 8-bit data, 8 address bits and two synchronizer stages. At these values the FIFO is small enough to fill to 255 words and drain completely in a few hundred cycles. Both warning boundaries, the dropped pushes and the dropped pops are therefore reached directly. The write clock runs at 50 MHz and the read clock at a 14 ns period with an offset, so the two clocks' rising edges never meet. Pointer crossings are thus exercised at many phase relations. Two mixed-traffic phases are included, one biased toward empty and one toward full.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  // One slot stays unused so a full array is distinguishable and the count fits AW bits.
  function automatic int unsigned usable_words(input int unsigned addr_bits);
    return (32'd1 << addr_bits) - 32'd1;
  endfunction

endpackage

// File: rtl/xfifo_rst_sync.sv
module xfifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/xfifo_ptr_sync.sv
module xfifo_ptr_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);

  logic [W-1:0] last_g;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    logic [W-1:0] q;
    if (g == 0) begin : g_head
      assign src = gray_in;
    end else begin : g_tail
      assign src = g_stage[g-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= src;
    end
  end

  assign last_g = g_stage[STAGES-1].q;

  always_comb begin
    for (int i = 0; i < W; i++) bin_out[i] = ^(last_g >> i);
  end

endmodule

// File: rtl/xfifo_wside.sv
module xfifo_wside #(
  parameter int AW = 8,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] rptr_sync,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [PW-1:0] wgray_q,
  output logic          full_q,
  output logic          afull_q,
  output logic [AW-1:0] count_q
);

  localparam int unsigned CAP = xfifo_pkg::usable_words(AW);
  localparam logic [PW-1:0] CAP_P   = PW'(CAP);
  localparam logic [PW-1:0] AFULL_P = PW'(CAP - 1);

  logic          push;
  logic [PW-1:0] wptr_q, wptr_d, wgray_d, occ_d;
  logic          full_d, afull_d;
  logic [AW-1:0] count_d;

  always_comb begin
    push    = wr_en && !full_q;
    wptr_d  = wptr_q + PW'(push);
    wgray_d = wptr_d ^ (wptr_d >> 1);
    occ_d   = wptr_d - rptr_sync;
    full_d  = (occ_d >= CAP_P);
    afull_d = (occ_d >= AFULL_P);
    count_d = occ_d[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wptr_q  <= wptr_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      afull_q <= 1'b0;
      count_q <= '0;
    end else begin
      full_q  <= full_d;
      afull_q <= afull_d;
      count_q <= count_d;
    end
  end

  assign mem_we    = push;
  assign mem_waddr = wptr_q[AW-1:0];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> (wptr_q == $past(wptr_q)));                               // R4
  AST_AFULL_COVERS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> afull_q);                                                 // R6
  AST_FULL_AT_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (count_q == CAP_P[AW-1:0]));                              // R3
  AST_WGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);                          // R9

endmodule

// File: rtl/xfifo_rside.sv
module xfifo_rside #(
  parameter int AW = 8,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] wptr_sync,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic [PW-1:0] rgray_q,
  output logic          empty_q,
  output logic          aempty_q,
  output logic [AW-1:0] count_q
);

  localparam logic [PW-1:0] ONE_P = PW'(1);

  logic          pop;
  logic [PW-1:0] rptr_q, rptr_d, rgray_d, occ_d;
  logic          empty_d, aempty_d;
  logic [AW-1:0] count_d;

  always_comb begin
    pop      = rd_en && !empty_q;
    rptr_d   = rptr_q + PW'(pop);
    rgray_d  = rptr_d ^ (rptr_d >> 1);
    occ_d    = wptr_sync - rptr_d;
    empty_d  = (occ_d == '0);
    aempty_d = (occ_d <= ONE_P);
    count_d  = occ_d[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      rgray_q <= '0;
    end else if (pop) begin
      rptr_q  <= rptr_d;
      rgray_q <= rgray_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
      count_q  <= '0;
    end else begin
      empty_q  <= empty_d;
      aempty_q <= aempty_d;
      count_q  <= count_d;
    end
  end

  assign mem_re    = pop;
  assign mem_raddr = rptr_q[AW-1:0];

  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q |=> (rptr_q == $past(rptr_q)));                              // R5
  AST_AEMPTY_COVERS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q |-> aempty_q);                                               // R7
  AST_RGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);                          // R9

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int DW          = 8,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  output logic          wr_almost_full,
  output logic [AW-1:0] wr_count,
  input  logic          rd_clk,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic          rd_almost_empty,
  output logic [AW-1:0] rd_count
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          w_rst_n, r_rst_n;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [PW-1:0] wgray, rgray, wptr_in_r, rptr_in_w;
  logic [DW-1:0] store_q [DEPTH];
  logic [DW-1:0] rdata_q;

  xfifo_rst_sync #(.STAGES(2)) i_wrst (.clk(wr_clk), .arst_n(rst_n), .rst_n(w_rst_n));
  xfifo_rst_sync #(.STAGES(2)) i_rrst (.clk(rd_clk), .arst_n(rst_n), .rst_n(r_rst_n));

  xfifo_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_w2r (
    .clk(rd_clk), .rst_n(r_rst_n), .gray_in(wgray), .bin_out(wptr_in_r));
  xfifo_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_r2w (
    .clk(wr_clk), .rst_n(w_rst_n), .gray_in(rgray), .bin_out(rptr_in_w));

  xfifo_wside #(.AW(AW)) i_wside (
    .clk(wr_clk), .rst_n(w_rst_n), .wr_en(wr_en), .rptr_sync(rptr_in_w),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .wgray_q(wgray),
    .full_q(wr_full), .afull_q(wr_almost_full), .count_q(wr_count));

  xfifo_rside #(.AW(AW)) i_rside (
    .clk(rd_clk), .rst_n(r_rst_n), .rd_en(rd_en), .wptr_sync(wptr_in_r),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .rgray_q(rgray),
    .empty_q(rd_empty), .aempty_q(rd_almost_empty), .count_q(rd_count));

  // Storage array: written in the write domain, no reset.
  always_ff @(posedge wr_clk) begin
    if (mem_we) store_q[mem_waddr] <= wr_data;
  end

  // Registered read port: one rd_clk cycle from accepted pop to data.
  always_ff @(posedge rd_clk or negedge r_rst_n) begin
    if (!r_rst_n)    rdata_q <= '0;
    else if (mem_re) rdata_q <= store_q[mem_raddr];
  end

  assign rd_data = rdata_q;

  AST_RDATA_HOLDS: assert property (@(posedge rd_clk) disable iff (!r_rst_n)
    !$past(mem_re) |-> $stable(rdata_q));                                // R5

endmodule

// File: tb/test_xclk_fifo.sv
module test_xclk_fifo;

  localparam int DW  = 8;
  localparam int AW  = 8;
  localparam int CAP = 255;

  logic          rst_n, wr_clk, rd_clk, wr_en, rd_en;
  logic [DW-1:0] wr_data, rd_data;
  logic          wr_full, wr_almost_full, rd_empty, rd_almost_empty;
  logic [AW-1:0] wr_count, rd_count;

  xclk_fifo #(.DW(DW), .AW(AW), .SYNC_STAGES(2)) i_xclk_fifo (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_almost_full(wr_almost_full), .wr_count(wr_count),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty), .rd_count(rd_count));

  int n_chk = 0;
  int n_bad = 0;
  int wr_total = 0;
  int rd_total = 0;
  bit finished = 0;
  logic [DW-1:0] model_q[$];
  bit wen_q = 0, wfull_prev = 0, ren_q = 0, rempty_prev = 1;
  logic [DW-1:0] wdat_q = '0, last_rd = '0;

  initial begin wr_clk = 0; forever #10 wr_clk = ~wr_clk; end
  initial begin rd_clk = 0; #6; forever #7 rd_clk = ~rd_clk; end

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // One write-clock cycle: account for the previous edge, compare, then drive.
  task automatic wcycle(input bit en, input logic [DW-1:0] d);
    @(negedge wr_clk);
    if (wen_q && !wfull_prev) begin
      model_q.push_back(wdat_q);
      wr_total++;
    end
    check(int'(wr_count) >= wr_total - rd_total, "R9 wr_count below occupancy",
          int'(wr_count), wr_total - rd_total);
    check(wr_full == (wr_count == AW'(CAP)), "R6 wr_full vs wr_count", int'(wr_full), int'(wr_count));
    check(wr_almost_full == (wr_count >= AW'(CAP - 1)), "R6 wr_almost_full vs wr_count",
          int'(wr_almost_full), int'(wr_count));
    wfull_prev = wr_full;
    wen_q = en; wdat_q = d;
    wr_en = en; wr_data = d;
  endtask

  // One read-clock cycle: check data of an accepted pop, compare, then drive.
  task automatic rcycle(input bit en);
    logic [DW-1:0] exp_d;
    @(negedge rd_clk);
    if (ren_q && !rempty_prev) begin
      if (model_q.size() == 0) begin
        check(0, "R9 pop accepted with nothing stored", int'(rd_data), -1);
      end else begin
        exp_d = model_q.pop_front();
        rd_total++;
        check(rd_data == exp_d, "R2 rd_data order", int'(rd_data), int'(exp_d));
      end
    end else begin
      check(rd_data == last_rd, "R5 rd_data held", int'(rd_data), int'(last_rd));
    end
    check(int'(rd_count) <= wr_total - rd_total, "R9 rd_count above occupancy",
          int'(rd_count), wr_total - rd_total);
    check(rd_empty == (rd_count == '0), "R7 rd_empty vs rd_count", int'(rd_empty), int'(rd_count));
    check(rd_almost_empty == (rd_count <= AW'(1)), "R7 rd_almost_empty vs rd_count",
          int'(rd_almost_empty), int'(rd_count));
    last_rd = rd_data;
    rempty_prev = rd_empty;
    ren_q = en;
    rd_en = en;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    int wd;
    int n;
    bit seen;
    rst_n = 0; wr_en = 0; rd_en = 0; wr_data = '0;
    #45;
    check(!wr_full && !wr_almost_full && wr_count == 0, "R1 write side during reset", int'(wr_count), 0);
    check(rd_empty && rd_almost_empty && rd_count == 0, "R1 read side during reset", int'(rd_empty), 1);
    #56 rst_n = 1;
    repeat (3) wcycle(0, '0);
    repeat (3) rcycle(0);
    check(wr_full == 0 && wr_almost_full == 0, "R1 write flags after reset", int'(wr_full), 0);
    check(wr_count == 0, "R1 wr_count after reset", int'(wr_count), 0);
    check(rd_empty == 1 && rd_almost_empty == 1, "R1 read flags after reset", int'(rd_empty), 1);
    check(rd_count == 0 && rd_data == 0, "R1 rd_count/rd_data after reset", int'(rd_count), 0);

    // Pops against an empty FIFO are dropped.
    repeat (4) rcycle(1);
    rcycle(0);
    check(rd_count == 0 && rd_empty, "R5 count after pops on empty", int'(rd_count), 0);
    check(rd_data == 0, "R5 rd_data after pops on empty", int'(rd_data), 0);

    // Fill until full; keep wr_en high so later pushes hit the full flag.
    wd = 0; seen = 0;
    while (wr_total < CAP && wd < 400) begin
      wcycle(1, DW'(wd));
      wd++;
      if (wr_total == CAP - 1 && !seen) begin
        seen = 1;
        check(wr_almost_full && !wr_full, "R6 almost-full one word early", int'(wr_almost_full), 1);
      end
    end
    check(wr_full == 1, "R3 wr_full at 255 words", int'(wr_full), 1);
    check(int'(wr_count) == CAP, "R3 wr_count at full", int'(wr_count), CAP);
    check(int'(rd_count) != CAP, "R9 read side not yet updated", int'(rd_count), CAP - 1);
    n = 0;
    while (int'(rd_count) != CAP && n < 10) begin rcycle(0); n++; end
    check(n <= 5, "R9 read side settles within five cycles", n, 5);
    check(int'(rd_count) == CAP && !rd_empty && !rd_almost_empty, "R8 rd_count after fill",
          int'(rd_count), CAP);

    // Pushes while full are dropped.
    for (int i = 0; i < 20; i++) begin wcycle(1, DW'(wd)); wd++; end
    wcycle(0, '0);
    check(wr_total == CAP, "R3 exactly 255 words accepted", wr_total, CAP);
    check(int'(wr_count) == CAP && wr_full, "R4 count unchanged by dropped pushes", int'(wr_count), CAP);

    // Drain everything.
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      rcycle(1);
      if (rd_total == CAP - 1 && !seen) begin
        seen = 1;
        check(rd_almost_empty && !rd_empty && rd_count == 1, "R7 almost-empty at one word",
              int'(rd_count), 1);
      end
    end
    rcycle(0);
    check(rd_total == CAP, "R2 all stored words read", rd_total, CAP);
    check(rd_empty && rd_count == 0, "R5 empty after drain", int'(rd_count), 0);
    check(rd_data == DW'(CAP - 1), "R4 dropped words never returned", int'(rd_data), CAP - 1);
    repeat (6) wcycle(0, '0);
    check(wr_count == 0 && !wr_full && !wr_almost_full, "R8 wr_count after drain", int'(wr_count), 0);

    // Mixed traffic, read-biased.
    fork
      begin
        for (int i = 0; i < 1500; i++) wcycle(((i * 7 + i / 3) % 5) != 0, DW'(i));
        wcycle(0, '0);
      end
      begin
        for (int i = 0; i < 2200; i++) rcycle(((i * 5 + i / 7) % 3) != 0);
        rcycle(0);
      end
    join
    // Mixed traffic, write-biased (reaches full).
    fork
      begin
        for (int i = 0; i < 1500; i++) wcycle(((i * 3) % 11) != 0, DW'(i * 3 + 1));
        wcycle(0, '0);
      end
      begin
        for (int i = 0; i < 2000; i++) rcycle(((i * 5 + i / 4) % 7) < 2);
        rcycle(0);
      end
    join
    repeat (6) rcycle(0);
    n = 0;
    while (model_q.size() > 0 && n < 600) begin rcycle(1); n++; end
    rcycle(0);
    repeat (6) rcycle(0);
    repeat (6) wcycle(0, '0);
    check(model_q.size() == 0 && rd_empty, "R2 mixed traffic fully returned", model_q.size(), 0);
    check(wr_count == 0 && rd_count == 0, "R8 counts settle after mixed traffic", int'(wr_count), 0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule